// File: doc/BRIEF.md
# Single-Symbol-Correcting Reed-Solomon Memory Codec

This block protects a memory word of sixteen 8-bit symbols with a Reed-Solomon code over GF(2^8). It can correct any one symbol in error. On the write side the encoder takes the data symbols and produces two check symbols. These are stored next to the data, so the stored word holds the data unchanged followed by the checks. On the read side the decoder takes the full 18-symbol word and forms two syndromes. From them it recovers the position and value of an error confined to one symbol, however many of that symbol's bits are flipped. It returns the repaired data with exactly one of three status flags.

Both paths are purely combinational. The parity-check matrix is symmetric: one row weights position i by α^i and the other by α^(-i). As a result, both check symbols cost the same number of constant multiplications, and so do both syndromes. No output waits on an unbalanced XOR tree. To locate an error the decoder divides the syndromes, takes a discrete logarithm and halves it modulo 255.

Top module: `rs_sec_codec`

## Requirements
- R1: Symbol i of any word occupies bits [8i+7:8i]. A stored word places data symbols 0..15 unchanged at positions 0..15 and check symbols `wr_check[7:0]` and `wr_check[15:8]` at positions 16 and 17.
- R2: For any data, the word {wr_check, wr_data} has both syndromes zero. Read back unmodified, it gives `rd_no_error` and `rd_data` equal to the data.
- R3: Arithmetic is in GF(2^8) with reduction polynomial x^8+x^4+x^3+x^2+1 (0x11D) and α = 0x02. The syndromes are S0 = Σ v_i·α^i and S1 = Σ v_i·α^(-i) over positions 0..17.
- R4: When both syndromes are zero, `rd_no_error` is 1 and `rd_data` equals the received data symbols.
- R5: Any nonzero error pattern added to any single data symbol (positions 0..15) yields `rd_corrected` and `rd_data` equal to the original data.
- R6: Exactly one of `rd_no_error`, `rd_corrected`, `rd_uncorrectable` is 1 for every input.
- R7: When exactly one syndrome is zero, `rd_uncorrectable` is 1 and `rd_data` equals the received data symbols.
- R8: When both syndromes are nonzero but the located position is 18 or above, `rd_uncorrectable` is 1 and `rd_data` equals the received data symbols.
- R9: A word with errors in exactly two symbols never reports `rd_no_error`.
- R10: A single-symbol error in a check symbol (position 16 or 17) yields `rd_corrected`, and `rd_data` equals the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data | input | 128 | Data symbols to encode, symbol i at bits [8i+7:8i] |
| wr_check | output | 16 | Check symbols for wr_data, position 16 in the low byte |
| rd_word | input | 144 | Received word: data symbols 0..15, then checks at 16 and 17 |
| rd_data | output | 128 | Data symbols after correction |
| rd_no_error | output | 1 | Both syndromes zero |
| rd_corrected | output | 1 | A single-symbol error was located and repaired |
| rd_uncorrectable | output | 1 | Syndromes inconsistent with any single-symbol error; data passed through |

## Verification
Immediate assertions in the RTL hold on every input. They check that exactly one flag is raised and that a located position lies inside the word with a nonzero value. They also check that data passes through untouched whenever nothing is repaired, and that reading back the encoder's own word shows no error. Only the bench's scenarios can show that the correction is right for every position and several error values. The same holds for the cases where only one syndrome is zero, where a crafted double error points beyond the codeword, and for random double errors. Each of these is compared against an independent brute-force search over positions.

// File: rtl/rs_sec_pkg.sv
package rs_sec_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W:0] GF_POLY = 9'h11D;
  localparam int GF_ORD = (1 << SYM_W) - 1;
  localparam int GF_HALF = 1 << (SYM_W - 1);   // inverse of 2 modulo GF_ORD
  localparam logic [SYM_W-1:0] INV_EXP = SYM_W'(GF_ORD - 1);

  typedef logic [SYM_W-1:0] sym_t;

  function automatic sym_t gf_xtime(sym_t a);
    return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? GF_POLY[SYM_W-1:0] : '0);
  endfunction

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc = '0;
    sym_t t = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ t;
      t = gf_xtime(t);
    end
    return acc;
  endfunction

  // alpha raised to any integer exponent, reduced modulo the group order
  function automatic sym_t gf_pow_alpha(int e);
    int r = e % GF_ORD;
    sym_t p = sym_t'(1);
    if (r < 0) r = r + GF_ORD;
    for (int i = 0; i < GF_ORD; i++)
      if (i < r) p = gf_xtime(p);
    return p;
  endfunction

  // a^(q-2) by square and multiply; maps zero to zero
  function automatic sym_t gf_inv(sym_t a);
    sym_t r = sym_t'(1);
    for (int i = SYM_W - 1; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (INV_EXP[i]) r = gf_mul(r, a);
    end
    return r;
  endfunction

  // discrete logarithm base alpha as a compare-select lookup
  function automatic int gf_log(sym_t a);
    int l = 0;
    sym_t p = sym_t'(1);
    for (int i = 0; i < GF_ORD; i++) begin
      if (p == a) l = i;
      p = gf_xtime(p);
    end
    return l;
  endfunction
endpackage

// File: rtl/rs_sec_encoder.sv
module rs_sec_encoder
  import rs_sec_pkg::*;
#(
  parameter int K = 16
) (
  input  logic [K*SYM_W-1:0] data,
  output sym_t               chk_lo,
  output sym_t               chk_hi
);
  // checks sit at positions K and K+1; Cramer's rule over the symmetric rows
  localparam sym_t DET_INV = gf_inv(gf_pow_alpha(1) ^ gf_pow_alpha(-1));

  sym_t term_lo [K];
  sym_t term_hi [K];

  for (genvar i = 0; i < K; i++) begin : g_term
    localparam sym_t C_LO = gf_mul(gf_pow_alpha(i - K - 1) ^ gf_pow_alpha(K + 1 - i), DET_INV);
    localparam sym_t C_HI = gf_mul(gf_pow_alpha(i - K) ^ gf_pow_alpha(K - i), DET_INV);
    assign term_lo[i] = gf_mul(data[i*SYM_W +: SYM_W], C_LO);
    assign term_hi[i] = gf_mul(data[i*SYM_W +: SYM_W], C_HI);
  end

  always_comb begin
    chk_lo = '0;
    chk_hi = '0;
    for (int i = 0; i < K; i++) begin
      chk_lo = chk_lo ^ term_lo[i];
      chk_hi = chk_hi ^ term_hi[i];
    end
  end
endmodule

// File: rtl/rs_sec_syndrome.sv
module rs_sec_syndrome
  import rs_sec_pkg::*;
#(
  parameter int N = 18
) (
  input  logic [N*SYM_W-1:0] word,
  output sym_t               syn_fwd,
  output sym_t               syn_rev
);
  sym_t prod_fwd [N];
  sym_t prod_rev [N];

  for (genvar i = 0; i < N; i++) begin : g_col
    localparam sym_t H_FWD = gf_pow_alpha(i);
    localparam sym_t H_REV = gf_pow_alpha(-i);
    assign prod_fwd[i] = gf_mul(word[i*SYM_W +: SYM_W], H_FWD);
    assign prod_rev[i] = gf_mul(word[i*SYM_W +: SYM_W], H_REV);
  end

  always_comb begin
    syn_fwd = '0;
    syn_rev = '0;
    for (int i = 0; i < N; i++) begin
      syn_fwd = syn_fwd ^ prod_fwd[i];
      syn_rev = syn_rev ^ prod_rev[i];
    end
  end
endmodule

// File: rtl/rs_sec_locator.sv
module rs_sec_locator
  import rs_sec_pkg::*;
#(
  parameter int N = 18
) (
  input  sym_t             syn_fwd,
  input  sym_t             syn_rev,
  output sym_t             err_val,
  output logic [SYM_W-1:0] err_pos,
  output logic             clean,
  output logic             fixed,
  output logic             broken
);
  sym_t ratio;
  int   ratio_log;
  int   pos_int;

  always_comb begin
    // syn_fwd/syn_rev = alpha^(2j); halve the log modulo the group order
    ratio     = gf_mul(syn_fwd, gf_inv(syn_rev));
    ratio_log = gf_log(ratio);
    pos_int   = (ratio_log * GF_HALF) % GF_ORD;
    err_pos   = SYM_W'(pos_int);
    err_val   = gf_mul(syn_fwd, gf_pow_alpha(GF_ORD - pos_int));
  end

  always_comb begin
    clean  = 1'b0;
    fixed  = 1'b0;
    broken = 1'b0;
    if (syn_fwd == '0 && syn_rev == '0) clean = 1'b1;
    else if (syn_fwd == '0 || syn_rev == '0) broken = 1'b1;
    else if (pos_int < N) fixed = 1'b1;
    else broken = 1'b1;
  end

  always_comb begin
    p_one_flag_r6: assert ($onehot({clean, fixed, broken}))
      else $error("status flags not one-hot");
    p_pos_range_r5: assert (!fixed || int'(err_pos) < N)
      else $error("corrected position outside codeword");
    p_value_nonzero_r5: assert (!fixed || err_val != '0)
      else $error("correction with zero error value");
  end
endmodule

// File: rtl/rs_sec_codec.sv
module rs_sec_codec
  import rs_sec_pkg::*;
#(
  parameter int K = 16
) (
  input  logic [K*SYM_W-1:0]     wr_data,
  output logic [2*SYM_W-1:0]     wr_check,
  input  logic [(K+2)*SYM_W-1:0] rd_word,
  output logic [K*SYM_W-1:0]     rd_data,
  output logic                   rd_no_error,
  output logic                   rd_corrected,
  output logic                   rd_uncorrectable
);
  localparam int N = K + 2;

  sym_t             chk_lo, chk_hi;
  sym_t             syn_fwd, syn_rev;
  sym_t             err_val;
  logic [SYM_W-1:0] err_pos;

  rs_sec_encoder #(.K(K)) u_enc (
    .data   (wr_data),
    .chk_lo (chk_lo),
    .chk_hi (chk_hi)
  );

  assign wr_check = {chk_hi, chk_lo};

  rs_sec_syndrome #(.N(N)) u_syn (
    .word    (rd_word),
    .syn_fwd (syn_fwd),
    .syn_rev (syn_rev)
  );

  rs_sec_locator #(.N(N)) u_loc (
    .syn_fwd (syn_fwd),
    .syn_rev (syn_rev),
    .err_val (err_val),
    .err_pos (err_pos),
    .clean   (rd_no_error),
    .fixed   (rd_corrected),
    .broken  (rd_uncorrectable)
  );

  for (genvar i = 0; i < K; i++) begin : g_fix
    assign rd_data[i*SYM_W +: SYM_W] = rd_word[i*SYM_W +: SYM_W]
        ^ ((rd_corrected && err_pos == SYM_W'(i)) ? err_val : '0);
  end

  always_comb begin
    p_clean_pass_r4: assert (!rd_no_error || rd_data == rd_word[K*SYM_W-1:0])
      else $error("data altered with no error");
    p_hold_on_bad_r7: assert (!rd_uncorrectable || rd_data == rd_word[K*SYM_W-1:0])
      else $error("data altered on uncorrectable word");
    p_encode_valid_r2: assert (rd_word != {wr_check, wr_data} || rd_no_error)
      else $error("encoded word not a codeword");
  end
endmodule

// File: tb/rs_sec_codec_tb.sv
module rs_sec_codec_tb;
  localparam int K = 16;
  localparam int N = K + 2;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [K*W-1:0] wr_data;
  logic [2*W-1:0] wr_check;
  logic [N*W-1:0] rd_word;
  logic [K*W-1:0] rd_data;
  logic rd_no_error, rd_corrected, rd_uncorrectable;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  rs_sec_codec #(.K(K)) u_dut (
    .wr_data(wr_data), .wr_check(wr_check), .rd_word(rd_word), .rd_data(rd_data),
    .rd_no_error(rd_no_error), .rd_corrected(rd_corrected),
    .rd_uncorrectable(rd_uncorrectable)
  );

  // ---- independent field model ----
  function automatic logic [7:0] b_xt(logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1D) : (a << 1);
  endfunction
  function automatic logic [7:0] b_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= t;
      t = b_xt(t);
    end
    return r;
  endfunction
  function automatic logic [7:0] b_ap(int e);
    int r = ((e % 255) + 255) % 255;
    logic [7:0] p = 8'h01;
    for (int i = 0; i < r; i++) p = b_xt(p);
    return p;
  endfunction
  function automatic logic [7:0] b_inv(logic [7:0] a);
    for (int x = 1; x < 256; x++) if (b_mul(a, 8'(x)) == 8'h01) return 8'(x);
    return 8'h00;
  endfunction
  function automatic logic [7:0] sym(logic [N*W-1:0] w, int i);
    return w[i*W +: W];
  endfunction

  // flag code: 0 no error, 1 corrected, 2 uncorrectable
  task automatic model(input logic [N*W-1:0] w, output int flag, output logic [K*W-1:0] dat);
    logic [7:0] s0 = 0, s1 = 0, e;
    for (int i = 0; i < N; i++) begin
      s0 ^= b_mul(sym(w, i), b_ap(i));
      s1 ^= b_mul(sym(w, i), b_ap(-i));
    end
    dat = w[K*W-1:0];
    flag = 2;
    if (s0 == 0 && s1 == 0) flag = 0;
    else if (s0 != 0 && s1 != 0)
      for (int j = 0; j < N; j++) begin
        e = b_mul(s0, b_ap(-j));
        if (b_mul(e, b_ap(-j)) == s1) begin
          flag = 1;
          if (j < K) dat[j*W +: W] = dat[j*W +: W] ^ e;
        end
      end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [N*W-1:0] w);
    @(negedge clk);
    rd_word = w;
    #1;
  endtask

  task automatic chk_read(input string req, input int eflag, input logic [K*W-1:0] edat);
    logic [2:0] ef;
    ef = (eflag == 0) ? 3'b100 : (eflag == 1) ? 3'b010 : 3'b001;
    chk({rd_no_error, rd_corrected, rd_uncorrectable} == ef, req, "flags",
        {rd_no_error, rd_corrected, rd_uncorrectable}, ef);
    chk(rd_data == edat, req, "data", rd_data, edat);
  endtask

  function automatic logic [K*W-1:0] rnd_data();
    logic [K*W-1:0] d;
    for (int i = 0; i < K / 4; i++) d[i*32 +: 32] = $urandom();
    return d;
  endfunction

  task automatic encode(input logic [K*W-1:0] d, output logic [N*W-1:0] cw);
    @(negedge clk);
    wr_data = d;
    #1;
    cw = {wr_check, d};
  endtask

  // R1 R4: all-zero data gives zero checks and a clean read
  task automatic t_zero();
    logic [N*W-1:0] cw;
    encode('0, cw);
    chk(wr_check == '0, "R1", "zero check", wr_check, 0);
    rd(cw);
    chk_read("R4", 0, '0);
  endtask

  // R1 R2 R3 R4: encoded words are codewords under the bench's own H
  task automatic t_encode();
    logic [N*W-1:0] cw;
    logic [K*W-1:0] d, md;
    int f;
    for (int t = 0; t < 8; t++) begin
      d = (t == 0) ? {K{8'hFF}} : (t == 1) ? {{(K-1){8'h00}}, 8'h01} : rnd_data();
      encode(d, cw);
      model(cw, f, md);
      chk(f == 0, "R3", "syndromes of encoded word", f, 0);
      chk(cw[K*W-1:0] == d, "R1", "systematic data", cw[K*W-1:0], d);
      rd(cw);
      chk_read("R2", 0, d);
    end
  endtask

  // R5 R10: every position, several error values
  task automatic t_single();
    logic [N*W-1:0] cw, w;
    logic [K*W-1:0] d;
    logic [7:0] ev;
    for (int p = 0; p < N; p++)
      for (int v = 0; v < 3; v++) begin
        d = rnd_data();
        encode(d, cw);
        ev = (v == 0) ? 8'h01 : (v == 1) ? 8'hFF : 8'($urandom_range(1, 255));
        w = cw;
        w[p*W +: W] = w[p*W +: W] ^ ev;
        rd(w);
        chk_read((p < K) ? "R5" : "R10", 1, d);
      end
  endtask

  // R7: errors at positions 0 and 1 cancelling one syndrome
  task automatic t_one_zero();
    logic [N*W-1:0] cw, w;
    logic [K*W-1:0] d;
    d = rnd_data();
    encode(d, cw);
    w = cw;
    w[0 +: W] ^= 8'h01;
    w[W +: W] ^= b_ap(-1);          // S0 cancels, S1 nonzero
    rd(w);
    chk_read("R7", 2, w[K*W-1:0]);
    w = cw;
    w[0 +: W] ^= 8'h01;
    w[W +: W] ^= b_ap(1);           // S1 cancels, S0 nonzero
    rd(w);
    chk_read("R7", 2, w[K*W-1:0]);
  endtask

  // R8: double error mimicking a unit error at position 100
  task automatic t_far();
    logic [N*W-1:0] cw, w;
    logic [K*W-1:0] d;
    logic [7:0] x, y;
    y = b_mul(b_ap(100) ^ b_ap(-100), b_inv(b_ap(1) ^ b_ap(-1)));
    x = b_ap(100) ^ b_mul(y, b_ap(1));
    d = rnd_data();
    encode(d, cw);
    w = cw;
    w[0 +: W] ^= x;
    w[W +: W] ^= y;
    rd(w);
    chk_read("R8", 2, w[K*W-1:0]);
  endtask

  // R9 R6: random double-symbol errors against the search model
  task automatic t_double();
    logic [N*W-1:0] cw, w;
    logic [K*W-1:0] md;
    int a, b, f;
    for (int t = 0; t < 150; t++) begin
      encode(rnd_data(), cw);
      a = $urandom_range(0, N - 1);
      b = (a + $urandom_range(1, N - 1)) % N;
      w = cw;
      w[a*W +: W] ^= 8'($urandom_range(1, 255));
      w[b*W +: W] ^= 8'($urandom_range(1, 255));
      rd(w);
      chk(!rd_no_error, "R9", "double error reported clean", rd_no_error, 0);
      model(w, f, md);
      chk_read("R6", f, md);
    end
  endtask

  initial begin
    wr_data = '0;
    rd_word = '0;
    void'($urandom(7));
    repeat (2) @(negedge clk);
    t_zero();
    t_encode();
    t_single();
    t_one_zero();
    t_far();
    t_double();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule